// File: doc/BRIEF.md
# Cartridge ADPCM Nibble Decoder

This block is a byte-wide register slave that turns a stream of 4-bit ADPCM codes into 8-bit unsigned PCM samples. Software switches the engine on through a control register. It then writes each ADPCM byte twice to a data register: the first write decodes the upper nibble and the second decodes the lower nibble. After each write it reads the new sample back from a third register. The decoder adapts its step size, keeps a 10-bit accumulator that wraps freely, and saturates only the 8-bit view that software reads.

The control register also holds a 7-bit timer reload value. While the engine is on, a periodic one-cycle tick is produced from a cartridge-rate clock enable. Bus reads have no side effects. Only writes change the engine's state.

Top module: `adpcm_nib_dec`

## Requirements
- R1: After reset, and after any control write that clears bit 7 while it was set, the sample register reads 0x80 (accumulator 0x100), the step index is 0 and the next decode uses bits 7:4. The control register resets to 0x00.
- R2: A control write that keeps bit 7 set while it is already set leaves the accumulator, step index and nibble phase unchanged.
- R3: A read of address 0 returns the last control byte written. A read of address 1 returns the last data byte written, whether the engine is on or off.
- R4: While bit 7 is set, each write to address 1 decodes one nibble. The first write after enable uses bits 7:4, the next uses bits 3:0, and the two alternate from then on. The new sample is readable in the clock cycle after the write.
- R5: A nibble's bit 3 is its sign and bits 2:0 its magnitude. The step-table entry selected by the current index and magnitude is added to the accumulator, or subtracted when the sign is set, modulo 1024.
- R6: After each decode the index changes by −1 for magnitudes 0–1, by 0 for 2–3, by +1 for 4, by +2 for 5–6 and by +3 for 7. The result is clamped to 0..15.
- R7: The sample is accumulator bits 8:1 for accumulator values 0x000–0x1FF, 0xFF for 0x200–0x2FF, and 0x00 for 0x300–0x3FF.
- R8: Writes to address 2 (the sample register) are ignored. Reads of any address never change decoder state.
- R9: While bit 7 is clear, writes to address 1 are still stored but decode nothing.
- R10: While bit 7 is set, timer_tick pulses for one cycle every (v+1)*2 cart_ce pulses, where v is control bits 6:0. While bit 7 is clear, no tick is produced.
- R11: bus_rdata is 0 when bus_rd is low, and it is 0 when address 3 is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cart_ce | input | 1 | One-cycle enable at the cartridge clock rate |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address: 0 control, 1 data, 2 sample |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| timer_tick | output | 1 | One-cycle periodic tick |

## Verification
The hardest states to reach from the ports are the two saturated accumulator bands, 0x200–0x2FF and 0x300–0x3FF. Getting there means driving the step index to its top and then pushing the sum across the 10-bit wrap. The bench does this with long runs of maximum-magnitude positive and negative codes, after sweeping all 256 byte values and a pseudo-random stream. It records which accumulator band each compared sample came from and requires that all four bands were visited. It also disables the engine in the middle of a stream and re-enables it, to confirm that decoding restarts on the upper nibble from the reset accumulator.

// File: rtl/adpcm_pkg.sv
package adpcm_pkg;

  localparam int ACC_W  = 10;
  localparam int IDX_W  = 4;
  localparam int BYTE_W = 8;
  localparam int TMR_W  = 7;

  localparam logic [ACC_W-1:0] ACC_INIT = ACC_W'(1 << (ACC_W - 2));
  localparam int IDX_MAX = (1 << IDX_W) - 1;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_DATA = 2'd1,
    REG_PCM  = 2'd2,
    REG_NONE = 2'd3
  } reg_addr_e;

  // Step row for an index; magnitude 0 in the top byte, magnitude 7 in the bottom byte.
  function automatic logic [63:0] step_row(input logic [IDX_W-1:0] idx);
    logic [63:0] r;
    case (idx)
      4'd0:  r = {8'd0, 8'd0,  8'd1,  8'd2,  8'd3,  8'd5,   8'd7,   8'd10};
      4'd1:  r = {8'd0, 8'd1,  8'd2,  8'd3,  8'd4,  8'd6,   8'd8,   8'd13};
      4'd2:  r = {8'd0, 8'd1,  8'd2,  8'd4,  8'd5,  8'd7,   8'd10,  8'd15};
      4'd3:  r = {8'd0, 8'd1,  8'd3,  8'd4,  8'd6,  8'd9,   8'd13,  8'd19};
      4'd4:  r = {8'd0, 8'd2,  8'd3,  8'd5,  8'd8,  8'd11,  8'd15,  8'd23};
      4'd5:  r = {8'd0, 8'd2,  8'd4,  8'd7,  8'd10, 8'd14,  8'd19,  8'd29};
      4'd6:  r = {8'd0, 8'd3,  8'd5,  8'd8,  8'd12, 8'd16,  8'd22,  8'd33};
      4'd7:  r = {8'd1, 8'd4,  8'd7,  8'd10, 8'd15, 8'd20,  8'd29,  8'd43};
      4'd8:  r = {8'd1, 8'd4,  8'd8,  8'd13, 8'd18, 8'd25,  8'd35,  8'd53};
      4'd9:  r = {8'd1, 8'd6,  8'd10, 8'd16, 8'd22, 8'd31,  8'd43,  8'd64};
      4'd10: r = {8'd2, 8'd7,  8'd12, 8'd19, 8'd27, 8'd37,  8'd51,  8'd76};
      4'd11: r = {8'd2, 8'd9,  8'd16, 8'd24, 8'd34, 8'd46,  8'd64,  8'd96};
      4'd12: r = {8'd3, 8'd11, 8'd19, 8'd29, 8'd41, 8'd57,  8'd79,  8'd117};
      4'd13: r = {8'd4, 8'd13, 8'd24, 8'd36, 8'd50, 8'd69,  8'd96,  8'd143};
      4'd14: r = {8'd4, 8'd16, 8'd29, 8'd44, 8'd62, 8'd85,  8'd118, 8'd175};
      default: r = {8'd6, 8'd20, 8'd36, 8'd54, 8'd76, 8'd104, 8'd144, 8'd214};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/adpcm_regs.sv
module adpcm_regs
  import adpcm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  input  logic [BYTE_W-1:0] pcm,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              eng_en,
  output logic              eng_clr,
  output logic              dec_go,
  output logic [TMR_W-1:0]  tmr_val
);

  logic [BYTE_W-1:0] ctrl_q, ctrl_n;
  logic [BYTE_W-1:0] data_q, data_n;
  logic              wr_ctrl, wr_data;

  assign wr_ctrl = bus_wr && (bus_addr == REG_CTRL);
  assign wr_data = bus_wr && (bus_addr == REG_DATA);

  always_comb begin
    ctrl_n = ctrl_q;
    data_n = data_q;
    if (wr_ctrl) ctrl_n = bus_wdata;
    if (wr_data) data_n = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      data_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_n;
      if (wr_data) data_q <= data_n;
    end
  end

  assign eng_en  = ctrl_q[BYTE_W-1];
  assign tmr_val = ctrl_q[TMR_W-1:0];
  // Engine reset only on an on-to-off transition of the enable bit.
  assign eng_clr = wr_ctrl && eng_en && !bus_wdata[BYTE_W-1];
  assign dec_go  = wr_data && eng_en;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        REG_CTRL: bus_rdata = ctrl_q;
        REG_DATA: bus_rdata = data_q;
        REG_PCM:  bus_rdata = pcm;
        default:  bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/adpcm_core.sv
module adpcm_core
  import adpcm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              go,
  input  logic [BYTE_W-1:0] code_byte,
  output logic [ACC_W-1:0]  acc,
  output logic [IDX_W-1:0]  idx,
  output logic              phase,
  output logic [BYTE_W-1:0] pcm
);

  logic [ACC_W-1:0] acc_q, acc_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic             ph_q, ph_n;
  logic             upd;

  logic [3:0]       nib;
  logic [2:0]       mag;
  logic [63:0]      row;
  logic [7:0]       diff;
  logic signed [IDX_W+1:0] idx_sum;
  logic signed [2:0]       idx_adj;

  assign upd = clr || go;
  assign nib = ph_q ? code_byte[3:0] : code_byte[7:4];
  assign mag = nib[2:0];
  assign row = step_row(idx_q);
  assign diff = row[63 - 8*mag -: 8];

  always_comb begin
    case (mag)
      3'd0, 3'd1: idx_adj = -3'sd1;
      3'd2, 3'd3: idx_adj = 3'sd0;
      3'd4:       idx_adj = 3'sd1;
      3'd5, 3'd6: idx_adj = 3'sd2;
      default:    idx_adj = 3'sd3;
    endcase
    idx_sum = $signed({2'b00, idx_q}) + (IDX_W+2)'(idx_adj);
  end

  always_comb begin
    acc_n = acc_q;
    idx_n = idx_q;
    ph_n  = ph_q;
    if (clr) begin
      acc_n = ACC_INIT;
      idx_n = '0;
      ph_n  = 1'b0;
    end else if (go) begin
      acc_n = nib[3] ? (acc_q - ACC_W'(diff)) : (acc_q + ACC_W'(diff));
      if (idx_sum < 0)
        idx_n = '0;
      else if (idx_sum > IDX_MAX)
        idx_n = IDX_W'(IDX_MAX);
      else
        idx_n = idx_sum[IDX_W-1:0];
      ph_n = !ph_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= ACC_INIT;
      idx_q <= '0;
      ph_q  <= 1'b0;
    end else if (upd) begin
      acc_q <= acc_n;
      idx_q <= idx_n;
      ph_q  <= ph_n;
    end
  end

  // Output-only saturation of the two upper accumulator bands.
  always_comb begin
    case (acc_q[ACC_W-1:ACC_W-2])
      2'b10:   pcm = '1;
      2'b11:   pcm = '0;
      default: pcm = acc_q[ACC_W-2:1];
    endcase
  end

  assign acc   = acc_q;
  assign idx   = idx_q;
  assign phase = ph_q;

endmodule

// File: rtl/adpcm_timer.sv
module adpcm_timer
  import adpcm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             ce,
  input  logic [TMR_W-1:0] val,
  output logic             tick
);

  localparam int CNT_W = TMR_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_n, reload;
  logic             tick_q, tick_n;

  // (val + 1) * 2 enable pulses per period: count 2*val+1 down to 0.
  assign reload = {val, 1'b1};

  always_comb begin
    cnt_n  = cnt_q;
    tick_n = 1'b0;
    if (!en) begin
      cnt_n = reload;
    end else if (ce) begin
      if (cnt_q == '0) begin
        cnt_n  = reload;
        tick_n = 1'b1;
      end else begin
        cnt_n = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      tick_q <= tick_n;
    end
  end

  assign tick = tick_q;

endmodule

// File: rtl/adpcm_nib_dec.sv
module adpcm_nib_dec
  import adpcm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cart_ce,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       timer_tick
);

  logic [1:0]       rst_sync_q;
  logic             rst_n_s;
  logic             eng_en, eng_clr, dec_go;
  logic [TMR_W-1:0] tmr_val;
  logic [ACC_W-1:0] acc_w;
  logic [IDX_W-1:0] idx_w;
  logic             phase_w;
  logic [7:0]       pcm_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  adpcm_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pcm       (pcm_w),
    .bus_rdata (bus_rdata),
    .eng_en    (eng_en),
    .eng_clr   (eng_clr),
    .dec_go    (dec_go),
    .tmr_val   (tmr_val)
  );

  adpcm_core u_core (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .clr       (eng_clr),
    .go        (dec_go),
    .code_byte (bus_wdata),
    .acc       (acc_w),
    .idx       (idx_w),
    .phase     (phase_w),
    .pcm       (pcm_w)
  );

  adpcm_timer u_timer (
    .clk   (clk),
    .rst_n (rst_n_s),
    .en    (eng_en),
    .ce    (cart_ce),
    .val   (tmr_val),
    .tick  (timer_tick)
  );

endmodule

// File: rtl/adpcm_nib_dec_chk.sv
module adpcm_nib_dec_chk (
  input logic       clk,
  input logic       rst_n_s,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [1:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic       timer_tick,
  input logic       eng_en,
  input logic       eng_clr,
  input logic       dec_go,
  input logic [9:0] acc_w,
  input logic [3:0] idx_w,
  input logic       phase_w
);

  assert_clr_state_R1: assert property (@(posedge clk) disable iff (!rst_n_s)
    eng_clr |=> (acc_w == 10'h100) && (idx_w == 4'd0) && !phase_w);

  assert_keep_on_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_wr && bus_addr == 2'd0 && bus_wdata[7] && eng_en)
      |=> $stable(acc_w) && $stable(idx_w) && $stable(phase_w));

  assert_phase_flip_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    dec_go |=> (phase_w != $past(phase_w)));

  assert_idx_step_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    dec_go |=> ({1'b0, idx_w} + 5'd1 >= {1'b0, $past(idx_w)})
            && ({1'b0, idx_w} <= {1'b0, $past(idx_w)} + 5'd3));

  assert_sat_hi_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_rd && bus_addr == 2'd2 && acc_w[9:8] == 2'b10) |-> bus_rdata == 8'hFF);

  assert_sat_lo_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_rd && bus_addr == 2'd2 && acc_w[9:8] == 2'b11) |-> bus_rdata == 8'h00);

  assert_pcm_wr_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_wr && bus_addr == 2'd2) |=> $stable(acc_w) && $stable(phase_w));

  assert_off_hold_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    !eng_en |=> $stable(acc_w) && $stable(phase_w));

  assert_tick_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    timer_tick |=> !timer_tick);

  assert_tick_off_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    !eng_en |=> !timer_tick);

  assert_idle_rd_R11: assert property (@(posedge clk) disable iff (!rst_n_s)
    !bus_rd |-> bus_rdata == 8'h00);

endmodule

bind adpcm_nib_dec adpcm_nib_dec_chk u_chk (
  .clk        (clk),
  .rst_n_s    (rst_n_s),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .timer_tick (timer_tick),
  .eng_en     (eng_en),
  .eng_clr    (eng_clr),
  .dec_go     (dec_go),
  .acc_w      (acc_w),
  .idx_w      (idx_w),
  .phase_w    (phase_w)
);

// File: tb/tb_adpcm_nib_dec.sv
module tb_adpcm_nib_dec;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cart_ce = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       timer_tick;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int m_acc, m_idx, m_ph;
  bit band_seen[4];

  always #10 clk = ~clk;

  adpcm_nib_dec dut (
    .clk(clk), .rst_n(rst_n), .cart_ce(cart_ce),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .timer_tick(timer_tick)
  );

  initial begin
    forever begin
      repeat (3) @(negedge clk);
      cart_ce = 1'b1;
      @(negedge clk);
      cart_ce = 1'b0;
    end
  end

  task automatic check(input int got, input int exp, input string req);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #3000000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  function automatic int ref_step(input int idx, input int mag);
    int t[8];
    case (idx)
      0:  t = '{0, 0, 1, 2, 3, 5, 7, 10};
      1:  t = '{0, 1, 2, 3, 4, 6, 8, 13};
      2:  t = '{0, 1, 2, 4, 5, 7, 10, 15};
      3:  t = '{0, 1, 3, 4, 6, 9, 13, 19};
      4:  t = '{0, 2, 3, 5, 8, 11, 15, 23};
      5:  t = '{0, 2, 4, 7, 10, 14, 19, 29};
      6:  t = '{0, 3, 5, 8, 12, 16, 22, 33};
      7:  t = '{1, 4, 7, 10, 15, 20, 29, 43};
      8:  t = '{1, 4, 8, 13, 18, 25, 35, 53};
      9:  t = '{1, 6, 10, 16, 22, 31, 43, 64};
      10: t = '{2, 7, 12, 19, 27, 37, 51, 76};
      11: t = '{2, 9, 16, 24, 34, 46, 64, 96};
      12: t = '{3, 11, 19, 29, 41, 57, 79, 117};
      13: t = '{4, 13, 24, 36, 50, 69, 96, 143};
      14: t = '{4, 16, 29, 44, 62, 85, 118, 175};
      default: t = '{6, 20, 36, 54, 76, 104, 144, 214};
    endcase
    return t[mag];
  endfunction

  function automatic int ref_pcm(input int a);
    if (a >= 'h300) return 0;
    if (a >= 'h200) return 'hFF;
    return a / 2;
  endfunction

  task automatic model_reset();
    m_acc = 'h100;
    m_idx = 0;
    m_ph  = 0;
  endtask

  task automatic model_decode(input int b);
    int nib, mag, d;
    int adj[8] = '{-1, -1, 0, 0, 1, 2, 2, 3};
    nib = (m_ph == 0) ? (b >> 4) & 15 : b & 15;
    mag = nib & 7;
    d = ref_step(m_idx, mag);
    m_acc = (nib & 8) ? m_acc - d : m_acc + d;
    m_acc = ((m_acc % 1024) + 1024) % 1024;
    m_idx = m_idx + adj[mag];
    if (m_idx < 0) m_idx = 0;
    if (m_idx > 15) m_idx = 15;
    m_ph = 1 - m_ph;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1;
    bus_addr = a;
    bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    bus_rd = 1'b1;
    #1;
    d = bus_rdata;
    bus_rd = 1'b0;
    #1;
  endtask

  // Writes one data byte and compares the sample with the model (R4, R5, R6, R7).
  task automatic feed(input int b, input string req);
    logic [7:0] s;
    bus_write(2'd1, 8'(b));
    model_decode(b);
    bus_read(2'd2, s);
    band_seen[m_acc >> 8] = 1'b1;
    check(s, ref_pcm(m_acc), req);
  endtask

  task automatic feed_pair(input int b, input string req);
    feed(b, req);
    feed(b, req);
  endtask

  task automatic wait_tick(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      @(posedge clk);
      #1;
      if (timer_tick) begin
        ok = 1'b1;
        break;
      end
    end
  endtask

  task automatic tick_gap(output int gap);
    bit ok;
    gap = -1;
    wait_tick(ok);
    if (!ok) return;
    wait_tick(ok);
    if (!ok) return;
    gap = 0;
    for (int i = 0; i < 4000; i++) begin
      @(posedge clk);
      #1;
      if (cart_ce) gap++;
      if (timer_tick) return;
    end
    gap = -1;
  endtask

  initial begin
    logic [7:0] r;
    int lfsr;
    int gap;
    int ticks;

    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    bus_read(2'd0, r); check(r, 0, "R1 control reset value");
    bus_read(2'd2, r); check(r, 'h80, "R1 sample after reset");

    // R11: idle read bus and unused address
    #1; check(bus_rdata, 0, "R11 rdata idle");
    bus_read(2'd3, r); check(r, 0, "R11 unused address");

    // R9: data latched but not decoded while off
    bus_write(2'd1, 8'h77);
    bus_write(2'd1, 8'h77);
    bus_read(2'd1, r); check(r, 'h77, "R9 data latched while off");
    bus_read(2'd2, r); check(r, 'h80, "R9 no decode while off");

    // R3: control readback, engine on
    bus_write(2'd0, 8'h82);
    bus_read(2'd0, r); check(r, 'h82, "R3 control readback");

    // R4/R5/R6: every byte value in order
    for (int b = 0; b < 256; b++) feed_pair(b, "R5 byte sweep");
    bus_read(2'd1, r); check(r, 'hFF, "R3 data readback");

    // R2: rewrite control with enable kept, model untouched
    bus_write(2'd0, 8'h85);
    bus_read(2'd2, r); check(r, ref_pcm(m_acc), "R2 sample after enable rewrite");
    feed_pair('h3C, "R2 decode after enable rewrite");

    // R8: write to sample address and reads have no effect
    bus_write(2'd2, 8'h12);
    bus_read(2'd2, r); check(r, ref_pcm(m_acc), "R8 sample write ignored");
    for (int k = 0; k < 5; k++) bus_read(2'(k % 3), r);
    feed_pair('hA1, "R8 decode after reads");

    // R4/R5/R6/R7: pseudo-random stream
    lfsr = 'hACE1;
    for (int k = 0; k < 2000; k++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 'hB400 : 0);
      feed_pair(lfsr & 'hFF, "R5 random stream");
    end

    // R6/R7: max positive and negative runs across the wrap
    for (int k = 0; k < 40; k++) feed('h77, "R7 positive run");
    for (int k = 0; k < 40; k++) feed('hFF, "R7 negative run");
    for (int k = 0; k < 8; k++) feed('h00, "R6 index decay");
    for (int k = 0; k < 40; k++) feed('h77, "R7 positive run 2");

    for (int k = 0; k < 4; k++)
      check(band_seen[k], 1, $sformatf("R7 accumulator band %0d visited", k));

    // R1: off transition resets; re-enable starts on upper nibble
    bus_write(2'd0, 8'h00);
    model_reset();
    bus_read(2'd2, r); check(r, 'h80, "R1 sample after disable");
    bus_write(2'd0, 8'h80);
    bus_read(2'd2, r); check(r, 'h80, "R1 sample after re-enable");
    feed('h70, "R4 upper nibble first");
    feed('h70, "R4 lower nibble second");
    feed('h70, "R4 upper nibble again");

    // R10: timer periods
    bus_write(2'd0, 8'h82);
    tick_gap(gap); check(gap, 6, "R10 period for value 2");
    bus_write(2'd0, 8'h80);
    tick_gap(gap); check(gap, 2, "R10 period for value 0");
    bus_write(2'd0, 8'h84);
    tick_gap(gap); check(gap, 10, "R10 period for value 4");

    // R10: no ticks while off
    bus_write(2'd0, 8'h04);
    ticks = 0;
    repeat (2) @(posedge clk);
    for (int i = 0; i < 300; i++) begin
      @(posedge clk);
      #1;
      if (timer_tick) ticks++;
    end
    check(ticks, 0, "R10 no ticks while off");

    finish_run();
  end

endmodule